// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table out of memory. A root register gives the page-aligned location of the first-level table (the directory). For each accepted request the walker reads one directory word. When that word points to a second-level table, it reads one word from that table. It then applies the user/supervisor and read/write permissions and returns either the physical address or a fault code.

On a successful walk the block also updates the used-bits that hardware maintains. The directory entry and the second-level entry each get their accessed flag set. On a write, the second-level entry also gets its modified flag set. These updates are written back to memory only when a bit actually changes, and they finish before the response appears.

A directory entry whose size flag is set maps a 4 MB region directly. In that case the walk ends after the first read. The block handles one walk at a time. It does not cache entries and does not perform the data access itself.

Top module: `xw_walker`

## Requirements
- R1: For a 4 KB mapping, `rsp_paddr` equals bits 31:12 of the second-level entry followed by virtual address bits 11:0, with `rsp_fault` = 0.
- R2: The directory word is read at {`dir_base`, va[31:22], 2'b00}, and the second-level word at {directory entry bits 31:12, va[21:12], 2'b00}.
- R3: If directory bit 0 (present) is 0, the response carries `rsp_fault` = 1 and `rsp_paddr` = 0, after exactly one read and no write.
- R4: If the second-level entry's bit 0 is 0, the response carries `rsp_fault` = 2 and `rsp_paddr` = 0, after two reads and no write.
- R5: The effective user-allowed flag is bit 2 and the effective writable flag is bit 1. For a 4 KB page each is the AND of both entries; for a 4 MB page each comes from the directory entry alone. A user request (`req_user` = 1) without user permission, or a write (`req_write` = 1) without write permission, in any mode, gives `rsp_fault` = 3 with `rsp_paddr` = 0 and no memory write.
- R6: After a successful walk, a directory entry whose accessed bit (bit 5) is clear is written back with bit 5 set. Then, for a 4 KB page, the second-level entry is written back with bit 5 set if that changes it. The directory write comes first, and no write happens when nothing would change.
- R7: The second-level entry's modified bit (bit 6) is set only by write requests; a read never sets it.
- R8: A directory entry with bit 7 set maps a 4 MB page. The result is entry bits 31:22 followed by va[21:0], with only one read.
- R9: `req_ready` is high only while idle. `mem_req` holds with a stable address until `mem_ack`. `rsp_valid` is a single-cycle pulse with no memory request alongside it.
- R10: During and right after reset, `rsp_valid` and `mem_req` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 20 | Page number of the directory |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| req_user | input | 1 | Request comes from user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 ok, 1 directory absent, 2 table absent, 3 permission |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench aims at the cases where the two levels interact. One case is a readable page whose directory forbids user access, which a walker that checks only the final entry would let through. Another is a 4 MB mapping, where a walker that ignores the size flag would issue a bogus second read and build the address from the wrong bits. The write-back cases cover a read over a clean page, which must leave the modified flag alone, and entries whose flags are already set, which must produce no write at all. A design that wrote the directory after the table, or that wrote on a faulting walk, would show up in the logged write order and count. Memory acknowledge delays are randomized, so a walker that dropped its request or changed address before the acknowledge would read the wrong word.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int VA_W   = OFF_W + 2 * IDX_W;
  localparam int BASE_W = VA_W - OFF_W;

  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int B_PS = 7;

  typedef logic [VA_W-1:0] entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_RD_TBL, S_WB_DIR, S_WB_TBL, S_RESP
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_DIR = 2'd1, FLT_TBL = 2'd2, FLT_PROT = 2'd3
  } fault_t;

  function automatic entry_t mark_used(entry_t e, logic set_dirty);
    entry_t r;
    r = e;
    r[B_A] = 1'b1;
    if (set_dirty) r[B_D] = 1'b1;
    return r;
  endfunction

  function automatic logic perm_fail(logic user, logic wr, logic us_ok, logic rw_ok);
    return (user && !us_ok) || (wr && !rw_ok);
  endfunction

  function automatic logic [VA_W-1:0] slot_addr(logic [BASE_W-1:0] base, logic [IDX_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} | (VA_W'(idx) << 2);
  endfunction

  function automatic logic [VA_W-1:0] pa_small(entry_t e, logic [VA_W-1:0] va);
    return {e[VA_W-1:OFF_W], va[OFF_W-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] pa_large(entry_t e, logic [VA_W-1:0] va);
    return {e[VA_W-1 -: IDX_W], va[OFF_W+IDX_W-1:0]};
  endfunction
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen import xw_pkg::*; (
  input  logic              second_lvl,
  input  logic [BASE_W-1:0] root_base,
  input  logic [BASE_W-1:0] table_base,
  input  logic [IDX_W-1:0]  dir_idx,
  input  logic [IDX_W-1:0]  tbl_idx,
  output logic [VA_W-1:0]   addr
);
  always_comb begin
    if (second_lvl) addr = slot_addr(table_base, tbl_idx);
    else            addr = slot_addr(root_base, dir_idx);
  end
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval import xw_pkg::*; #(
  parameter bit IS_TABLE = 1'b0
) (
  input  entry_t ent,
  input  logic   wr,
  output logic   present,
  output logic   user_ok,
  output logic   write_ok,
  output logic   need_wb,
  output entry_t wb_val
);
  always_comb begin
    present  = ent[B_P];
    user_ok  = ent[B_US];
    write_ok = ent[B_RW];
    wb_val   = mark_used(ent, wr && IS_TABLE);
    need_wb  = (wb_val != ent);
  end
endmodule

// File: rtl/xw_walker.sv
module xw_walker import xw_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] dir_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [VA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req,
  output logic              mem_we,
  output logic [VA_W-1:0]   mem_addr,
  output logic [VA_W-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [VA_W-1:0]   mem_rdata
);
  walk_state_t       state;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, user_q;
  entry_t            dir_q, tbl_q;
  logic [VA_W-1:0]   paddr_q;
  fault_t            fault_q;

  // named internal events
  entry_t dir_src, tbl_src;
  logic   d_present, d_us, d_rw, d_need, d_large;
  logic   t_present, t_us, t_rw, t_need;
  entry_t d_wb, t_wb;
  logic   prot_big, prot_small, walk_start, second_lvl;

  assign dir_src = (state == S_RD_DIR) ? mem_rdata : dir_q;
  assign tbl_src = (state == S_RD_TBL) ? mem_rdata : tbl_q;
  assign d_large = dir_src[B_PS];

  xw_entry_eval #(.IS_TABLE(1'b0)) u_dir_eval (
    .ent(dir_src), .wr(wr_q), .present(d_present), .user_ok(d_us),
    .write_ok(d_rw), .need_wb(d_need), .wb_val(d_wb));

  xw_entry_eval #(.IS_TABLE(1'b1)) u_tbl_eval (
    .ent(tbl_src), .wr(wr_q), .present(t_present), .user_ok(t_us),
    .write_ok(t_rw), .need_wb(t_need), .wb_val(t_wb));

  assign prot_big   = perm_fail(user_q, wr_q, d_us, d_rw);
  assign prot_small = perm_fail(user_q, wr_q, d_us & t_us, d_rw & t_rw);
  assign walk_start = req_valid && req_ready;
  assign second_lvl = (state == S_RD_TBL) || (state == S_WB_TBL);

  xw_addr_gen u_addr (
    .second_lvl(second_lvl), .root_base(dir_base),
    .table_base(dir_q[VA_W-1:OFF_W]),
    .dir_idx(va_q[VA_W-1 -: IDX_W]),
    .tbl_idx(va_q[OFF_W+IDX_W-1:OFF_W]),
    .addr(mem_addr));

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
  assign mem_req   = (state == S_RD_DIR) || (state == S_RD_TBL) ||
                     (state == S_WB_DIR) || (state == S_WB_TBL);
  assign mem_we    = (state == S_WB_DIR) || (state == S_WB_TBL);
  assign mem_wdata = (state == S_WB_DIR) ? d_wb :
                     (state == S_WB_TBL) ? t_wb : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      dir_q   <= '0;
      tbl_q   <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      case (state)
        S_IDLE: if (walk_start) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          user_q  <= req_user;
          paddr_q <= '0;
          fault_q <= FLT_NONE;
          state   <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_ack) begin
          dir_q <= mem_rdata;
          if (!d_present) begin
            fault_q <= FLT_DIR;
            state   <= S_RESP;
          end else if (d_large) begin
            if (prot_big) begin
              fault_q <= FLT_PROT;
              state   <= S_RESP;
            end else begin
              paddr_q <= pa_large(mem_rdata, va_q);
              state   <= d_need ? S_WB_DIR : S_RESP;
            end
          end else begin
            state <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_ack) begin
          tbl_q <= mem_rdata;
          if (!t_present) begin
            fault_q <= FLT_TBL;
            state   <= S_RESP;
          end else if (prot_small) begin
            fault_q <= FLT_PROT;
            state   <= S_RESP;
          end else begin
            paddr_q <= pa_small(mem_rdata, va_q);
            state   <= d_need ? S_WB_DIR : (t_need ? S_WB_TBL : S_RESP);
          end
        end
        S_WB_DIR: if (mem_ack) state <= (!d_large && t_need) ? S_WB_TBL : S_RESP;
        S_WB_TBL: if (mem_ack) state <= S_RESP;
        S_RESP:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);
  // R9
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req && !req_ready);
  // R6
  wb_sets_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_A]);
  // R1
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'd0 |-> rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]);
  // R3, R4, R5
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0);
endmodule

// File: tb/xw_walker_test.sv
`timescale 1ns/1ps
module xw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] dir_base = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, mem_req, mem_we;
  logic [31:0] rsp_paddr, mem_addr, mem_wdata;
  logic [1:0]  rsp_fault;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  xw_walker uut (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_user(req_user), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata));

  logic [31:0] mem [logic [31:0]];
  int nchk = 0, nfail = 0;
  int nrd = 0, nwr = 0;
  logic [31:0] rd_a [4];
  logic [31:0] wr_a [4];
  logic [31:0] wr_d [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder with random acknowledge delay
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (dly > 0) dly--;
        else begin
          if (mem_we) begin
            if (nwr < 4) begin wr_a[nwr] = mem_addr; wr_d[nwr] = mem_wdata; end
            nwr++;
            mem[mem_addr] = mem_wdata;
          end else begin
            if (nrd < 4) rd_a[nrd] = mem_addr;
            nrd++;
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
          end
          mem_ack = 1'b1;
          dly = $urandom % 3;
        end
      end
    end
  end

  function automatic bit perm_bad(bit usr, bit wr, bit us, bit rw);
    return (usr && !us) || (wr && !rw);
  endfunction

  task automatic run(input logic [31:0] va, input bit wr, input bit usr,
                     input logic [19:0] base, input logic [31:0] pde_in,
                     input logic [31:0] pte_in, input string ftag);
    logic [31:0] pde, pte, da, ta, e_pa, npte;
    logic [31:0] e_wa [2];
    logic [31:0] e_wd [2];
    int e_flt, e_nrd, e_nwr, cnt;
    pde = pde_in; pte = pte_in;
    da = {base, va[31:22], 2'b00};
    ta = {pde[31:12], va[21:12], 2'b00};
    if (ta == da) begin pde[12] = ~pde[12]; ta = {pde[31:12], va[21:12], 2'b00}; end
    mem.delete();
    mem[da] = pde;
    if (!pde[7]) mem[ta] = pte;
    e_nwr = 0; e_pa = 0; e_flt = 0;
    if (!pde[0]) begin e_flt = 1; e_nrd = 1; end
    else if (pde[7]) begin
      e_nrd = 1;
      if (perm_bad(usr, wr, pde[2], pde[1])) e_flt = 3;
      else begin
        e_pa = {pde[31:22], va[21:0]};
        if (!pde[5]) begin e_wa[0] = da; e_wd[0] = pde | 32'h20; e_nwr = 1; end
      end
    end else begin
      e_nrd = 2;
      if (!pte[0]) e_flt = 2;
      else if (perm_bad(usr, wr, pde[2] & pte[2], pde[1] & pte[1])) e_flt = 3;
      else begin
        e_pa = {pte[31:12], va[11:0]};
        if (!pde[5]) begin e_wa[e_nwr] = da; e_wd[e_nwr] = pde | 32'h20; e_nwr++; end
        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (npte != pte) begin e_wa[e_nwr] = ta; e_wd[e_nwr] = npte; e_nwr++; end
      end
    end
    @(negedge clk);
    dir_base = base; req_vaddr = va; req_write = wr; req_user = usr;
    req_valid = 1'b1; nrd = 0; nwr = 0;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!rsp_valid && cnt < 100) begin @(negedge clk); cnt++; end
    chk(rsp_valid, "R9", "response seen", 32'(rsp_valid), 32'h1);
    chk(!req_ready, "R9", "ready low at response", 32'(req_ready), 32'h0);
    chk(rsp_fault == 2'(e_flt), ftag, "fault code", 32'(rsp_fault), 32'(e_flt));
    chk(rsp_paddr == e_pa, pde[7] ? "R8" : "R1", "physical address", rsp_paddr, e_pa);
    chk(nrd == e_nrd, pde[7] ? "R8" : "R2", "read count", 32'(nrd), 32'(e_nrd));
    chk(rd_a[0] == da, "R2", "directory address", rd_a[0], da);
    if (e_nrd == 2 && nrd >= 2) chk(rd_a[1] == ta, "R2", "table address", rd_a[1], ta);
    chk(nwr == e_nwr, "R6", "write-back count", 32'(nwr), 32'(e_nwr));
    for (int k = 0; k < 2; k++) begin
      if (k < e_nwr && k < nwr) begin
        chk(wr_a[k] == e_wa[k], "R6", "write-back address", wr_a[k], e_wa[k]);
        chk(wr_d[k] == e_wd[k], wr ? "R7" : "R6", "write-back data", wr_d[k], e_wd[k]);
      end
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R9", "single-cycle response", 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 during reset
    chk(!rsp_valid && !mem_req, "R10", "outputs quiet in reset", {rsp_valid, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R10", "idle after reset",
        {req_ready, mem_req, rsp_valid}, 32'h4);

    // directed corner cases
    run(32'h1234_5678, 0, 0, 20'h00100, 32'h00300_006, 32'h0, "R3");       // dir absent
    run(32'h0040_1abc, 0, 0, 20'h00100, 32'h00300_007, 32'h00500_006, "R4"); // table absent
    run(32'h0040_1abc, 0, 1, 20'h00100, 32'h00300_007, 32'h00500_003, "R5"); // user on sup page
    run(32'h0040_1abc, 0, 1, 20'h00100, 32'h00300_003, 32'h00500_007, "R5"); // dir forbids user
    run(32'h0040_1abc, 1, 0, 20'h00100, 32'h00300_005, 32'h00500_007, "R5"); // write read-only
    run(32'h0040_1abc, 0, 1, 20'h00100, 32'h00300_007, 32'h00500_007, "R6"); // both A clear
    run(32'h0040_1abc, 0, 0, 20'h00100, 32'h00300_027, 32'h00500_027, "R7"); // read, no D
    run(32'h0040_1abc, 1, 0, 20'h00100, 32'h00300_027, 32'h00500_027, "R7"); // write sets D
    run(32'h0040_1abc, 1, 0, 20'h00100, 32'h00300_007, 32'h00500_067, "R6"); // dir only
    run(32'h0040_1abc, 1, 1, 20'h00100, 32'h00300_067, 32'h00500_067, "R6"); // nothing changes
    run(32'hABC1_2345, 0, 1, 20'h00100, 32'h55400_087, 32'h0, "R8");        // 4 MB page
    run(32'hABC1_2345, 1, 1, 20'h00100, 32'h55400_0A7, 32'h0, "R8");        // 4 MB, A set
    run(32'hABC1_2345, 0, 1, 20'h00100, 32'h55400_083, 32'h0, "R5");        // 4 MB sup only

    // constrained random walks
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pde, pte;
      pde = $urandom; pte = $urandom;
      pde[0] = ($urandom % 8) != 0;
      pde[7] = ($urandom % 4) == 0;
      pte[0] = ($urandom % 8) != 0;
      run($urandom, 1'($urandom), 1'($urandom), 20'($urandom), pde, pte, "R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule